// File: doc/BRIEF.md
# Paged Host Register File for an Ethernet Controller

This block is the host-facing register front end of a small Ethernet controller. A host reaches it over a byte-wide synchronous bus with sixteen byte addresses. Address 0 always holds the command byte. The top two bits of that byte select one of four register pages, and those pages reuse the remaining fifteen addresses. The block keeps the registers that the receive path, the transmit path and the remote DMA engine need. It presents their values on output ports, so the packet memory logic and the DMA engine beside it can use them directly.

The block also owns the interrupt logic: a status byte, a mask byte and one level-sensitive interrupt line. Status bits are set by side effects of command writes and by reset. The host clears them with a write-one-to-clear access. A transmit request is modelled only as a one-cycle start pulse plus an immediate completion report. Packet memory and the data movers are not part of this block.

Top module: `nic_page_regs`

## Requirements
- R1: Address 0 reads and writes the command byte on every page. Any other address selects register page*16+address, where page is command bits [7:6]. A write to a nonzero address never changes the command byte.
- R2: The interrupt output is high exactly when status AND mask AND 0x7F is nonzero. It changes in the cycle after the write that alters status or mask. Status bit 7 never raises it. Mask is written at page 0 address 15.
- R3: Writing status (page 0 address 7) clears every status bit in [6:0] whose written bit is 1. Status bit 7 is not affected by this write.
- R4: Status bit 7 (reset flag) is cleared by a command write with bit 0 (halt) equal to 0. A command write with bit 0 equal to 1 leaves it set.
- R5: A command write with bit 0 = 0 and bit 3 or bit 4 set, while the remote DMA count is zero, sets status bit 6. The same write with a nonzero count leaves bit 6 clear.
- R6: A command write with bit 0 = 0 and bit 2 set causes the following effects. tx_start is high for exactly one cycle. Transmit status (page 0 address 4 read) becomes 0x01. Status bit 1 is set. The stored command reads back with bit 2 cleared. With bit 0 = 1 there is no pulse, and the command is stored as written.
- R7: The 16-bit registers are written as separate bytes, and writing one byte keeps the other: transmit count (page 0 addresses 5/6), remote DMA address (8/9, readable) and remote DMA count (10/11). The transmit page (4), receive config (12) and data config (14) are single-byte registers. All of these drive output ports.
- R8: Writes to ring start (page 0 address 1) and ring stop (page 0 address 2) are ignored when the value is above END_PAGE. Writes to boundary (page 0 address 3) and current page (page 1 address 7) are ignored when the value is at or above END_PAGE.
- R9: Reads of any address not mapped on the current page return 0. Page 2 addresses 1 and 2 return ring start and ring stop. Page 0 addresses 10 and 11 return 0x50 and 0x43.
- R10: Read data is registered. It appears the cycle after a read strobe and holds its value until the next read.
- R11: Page 1 addresses 1 to 6 hold the six station address bytes, and addresses 8 to 15 hold the eight multicast filter bytes. All of them can be written and read back.
- R12: After reset, the command reads 0x01, status reads 0x80, and interrupt and tx_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for a bus access |
| we | input | 1 | 1 = write, 0 = read (with cs) |
| addr | input | 4 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |
| tx_start | output | 1 | One-cycle transmit start pulse |
| tx_page | output | 8 | Transmit start page |
| tx_count | output | 16 | Transmit byte count |
| dma_addr | output | 16 | Remote DMA address |
| dma_count | output | 16 | Remote DMA byte count |
| rx_cfg | output | 8 | Receive configuration byte |
| data_cfg | output | 8 | Data configuration byte |

## Verification
The hardest situations to reach are the interactions between status side effects and the reset flag. The reset flag exists only until the first command write with halt clear. So the W1C check on bit 7, and the check that a halted command keeps the flag, must run before any page switch, and only halted command writes may come first. The remote-DMA-complete path also depends on the count register being zero. The stimulus therefore fires the remote-read command before the count is ever loaded, then loads a nonzero count and repeats the command to show the bit stays clear. Page boundary values are driven at END_PAGE exactly and one above it, so the different acceptance rules for ring limits and for boundary/current page separate.

// File: rtl/nic_page_pkg.sv
package nic_page_pkg;
  localparam int DW = 8;
  localparam int AW = 4;

  typedef enum logic [1:0] {
    PG_MAIN    = 2'd0,
    PG_STATION = 2'd1,
    PG_RINGRD  = 2'd2,
    PG_SPARE   = 2'd3
  } page_e;

  // command bit positions
  localparam int CB_HALT  = 0;
  localparam int CB_XMIT  = 2;
  localparam int CB_DMARD = 3;
  localparam int CB_DMAWR = 4;

  // status bit positions
  localparam int SB_XMIT_DONE = 1;
  localparam int SB_DMA_DONE  = 6;
  localparam int SB_RST_FLAG  = 7;

  localparam logic [7:0] CMD_INIT  = 8'h01;
  localparam logic [7:0] STS_INIT  = 8'h80;
  localparam logic [7:0] IRQ_BITS  = 8'h7F;
  localparam logic [7:0] XMIT_OK   = 8'h01;
  localparam logic [7:0] ID_BYTE_A = 8'h50;
  localparam logic [7:0] ID_BYTE_B = 8'h43;

  // page-0 addresses
  localparam logic [3:0] A_RSTART = 4'h1;
  localparam logic [3:0] A_RSTOP  = 4'h2;
  localparam logic [3:0] A_BOUND  = 4'h3;
  localparam logic [3:0] A_TXPG   = 4'h4;
  localparam logic [3:0] A_TXC_LO = 4'h5;
  localparam logic [3:0] A_TXC_HI = 4'h6;
  localparam logic [3:0] A_STATUS = 4'h7;
  localparam logic [3:0] A_DMA_LO = 4'h8;
  localparam logic [3:0] A_DMA_HI = 4'h9;
  localparam logic [3:0] A_CNT_LO = 4'hA;
  localparam logic [3:0] A_CNT_HI = 4'hB;
  localparam logic [3:0] A_RXCFG  = 4'hC;
  localparam logic [3:0] A_DCFG   = 4'hE;
  localparam logic [3:0] A_MASK   = 4'hF;
  // page-1 addresses
  localparam logic [3:0] A_CURPG  = 4'h7;
  localparam int         STA_BASE = 1;
  localparam int         MC_BASE  = 8;
endpackage

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_page_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_wdata,
  input  logic [DW-1:0] clr_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] sts_o,
  output logic          irq_o
);
  logic [DW-1:0] sts_q, sts_d, mask_q, mask_d;
  logic          irq_q, irq_d;

  always_comb begin
    sts_d  = (sts_q & ~clr_i) | set_i;
    mask_d = mask_we ? mask_wdata : mask_q;
    irq_d  = |(sts_d & mask_d & IRQ_BITS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= STS_INIT;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      sts_q  <= sts_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = irq_q;

  // R2: the reset flag alone can never hold the line high
  a_r2_flag_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q[6:0] & mask_q[6:0]) == '0) |-> !irq_q);
  // R3: bits named in a clear vector are gone the next cycle
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i[6:0] != '0) && (set_i == '0)) |=> ((sts_q[6:0] & $past(clr_i[6:0])) == '0));
  // R4: the reset flag is never raised outside reset
  a_r4_flag_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sts_q[SB_RST_FLAG]));
endmodule

// File: rtl/nic_split_reg.sv
module nic_split_reg
  import nic_page_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH/DW-1:0] byte_we,
  input  logic [DW-1:0]    wdata,
  output logic [WIDTH-1:0] value_o
);
  localparam int NBYTES = WIDTH / DW;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [DW-1:0] q, d;
    always_comb d = byte_we[b] ? wdata : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign value_o[b*DW +: DW] = q;
  end
endmodule

// File: rtl/nic_ring_ptrs.sv
module nic_ring_ptrs
  import nic_page_pkg::*;
#(
  parameter int END_PAGE = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_we,
  input  logic          stop_we,
  input  logic          bound_we,
  input  logic          cur_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] start_o,
  output logic [DW-1:0] stop_o,
  output logic [DW-1:0] bound_o,
  output logic [DW-1:0] cur_o
);
  logic [DW-1:0] start_q, stop_q, bound_q, cur_q;
  logic [DW-1:0] start_d, stop_d, bound_d, cur_d;
  logic          lim_ok, ptr_ok;

  always_comb begin
    lim_ok  = int'(wdata) <= END_PAGE;
    ptr_ok  = int'(wdata) <  END_PAGE;
    start_d = (start_we && lim_ok) ? wdata : start_q;
    stop_d  = (stop_we  && lim_ok) ? wdata : stop_q;
    bound_d = (bound_we && ptr_ok) ? wdata : bound_q;
    cur_d   = (cur_we   && ptr_ok) ? wdata : cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      stop_q  <= '0;
      bound_q <= '0;
      cur_q   <= '0;
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
      bound_q <= bound_d;
      cur_q   <= cur_d;
    end
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign bound_o = bound_q;
  assign cur_o   = cur_q;

  // R8: a write beyond the limit leaves the ring limit untouched
  a_r8_limit_reject: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_we || stop_we) && int'(wdata) > END_PAGE) |=> ($stable(start_q) && $stable(stop_q)));
  // R8: a pointer write at or beyond the limit is dropped
  a_r8_ptr_reject: assert property (@(posedge clk) disable iff (!rst_n)
    ((bound_we || cur_we) && int'(wdata) >= END_PAGE) |=> ($stable(bound_q) && $stable(cur_q)));
endmodule

// File: rtl/nic_page_regs.sv
module nic_page_regs
  import nic_page_pkg::*;
#(
  parameter int END_PAGE  = 128,
  parameter int STA_BYTES = 6,
  parameter int MC_BYTES  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          tx_start,
  output logic [DW-1:0] tx_page,
  output logic [15:0]   tx_count,
  output logic [15:0]   dma_addr,
  output logic [15:0]   dma_count,
  output logic [DW-1:0] rx_cfg,
  output logic [DW-1:0] data_cfg
);
  localparam int CNT_W = 16;
  localparam int CNT_B = CNT_W / DW;

  logic          wr, rd, cmd_wr, reg_wr, run_cmd;
  page_e         page;
  logic [DW-1:0] cmd_q, cmd_d, txs_q, txs_d, txpg_q, txpg_d;
  logic [DW-1:0] rxc_q, rxc_d, dcf_q, dcf_d, rdata_q, rdata_d, rd_val;
  logic          txgo_q, xmit_go, dma_done_set;
  logic [DW-1:0] set_vec, clr_vec, sts;
  logic [DW-1:0] rs_start, rs_stop, rs_bound, rs_cur;
  logic [DW-1:0] sta_q [STA_BYTES];
  logic [DW-1:0] mc_q  [MC_BYTES];

  // ---------------- access decode
  always_comb begin
    wr      = cs && we;
    rd      = cs && !we;
    cmd_wr  = wr && (addr == '0);
    reg_wr  = wr && (addr != '0);
    page    = page_e'(cmd_q[7:6]);
    run_cmd = cmd_wr && !wdata[CB_HALT];
    xmit_go = run_cmd && wdata[CB_XMIT];
    dma_done_set = run_cmd && (wdata[CB_DMARD] || wdata[CB_DMAWR]) && (dma_count == '0);
  end

  function automatic logic p0w(input logic [AW-1:0] a);
    return reg_wr && (page == PG_MAIN) && (addr == a);
  endfunction

  // ---------------- command, transmit and single-byte registers
  always_comb begin
    cmd_d = cmd_q;
    if (cmd_wr) begin
      cmd_d = wdata;
      if (xmit_go) cmd_d[CB_XMIT] = 1'b0;
    end
    txs_d  = xmit_go           ? XMIT_OK : txs_q;
    txpg_d = p0w(A_TXPG)       ? wdata   : txpg_q;
    rxc_d  = p0w(A_RXCFG)      ? wdata   : rxc_q;
    dcf_d  = p0w(A_DCFG)       ? wdata   : dcf_q;
    set_vec = '0;
    set_vec[SB_XMIT_DONE] = xmit_go;
    set_vec[SB_DMA_DONE]  = dma_done_set;
    clr_vec = '0;
    if (p0w(A_STATUS)) clr_vec = wdata & IRQ_BITS;
    clr_vec[SB_RST_FLAG] = run_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_INIT;
      txs_q  <= '0;
      txpg_q <= '0;
      rxc_q  <= '0;
      dcf_q  <= '0;
      txgo_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      txs_q  <= txs_d;
      txpg_q <= txpg_d;
      rxc_q  <= rxc_d;
      dcf_q  <= dcf_d;
      txgo_q <= xmit_go;
    end
  end

  // ---------------- 16-bit split registers
  nic_split_reg #(.WIDTH(CNT_W)) u_txcnt (
    .clk, .rst_n, .byte_we({p0w(A_TXC_HI), p0w(A_TXC_LO)}), .wdata, .value_o(tx_count));
  nic_split_reg #(.WIDTH(CNT_W)) u_dmaaddr (
    .clk, .rst_n, .byte_we({p0w(A_DMA_HI), p0w(A_DMA_LO)}), .wdata, .value_o(dma_addr));
  nic_split_reg #(.WIDTH(CNT_W)) u_dmacnt (
    .clk, .rst_n, .byte_we({p0w(A_CNT_HI), p0w(A_CNT_LO)}), .wdata, .value_o(dma_count));

  // ---------------- ring pointers
  nic_ring_ptrs #(.END_PAGE(END_PAGE)) u_ring (
    .clk, .rst_n,
    .start_we(p0w(A_RSTART)), .stop_we(p0w(A_RSTOP)), .bound_we(p0w(A_BOUND)),
    .cur_we(reg_wr && page == PG_STATION && addr == A_CURPG),
    .wdata, .start_o(rs_start), .stop_o(rs_stop), .bound_o(rs_bound), .cur_o(rs_cur));

  // ---------------- interrupt status and mask
  nic_irq_ctrl u_irq (
    .clk, .rst_n, .mask_we(p0w(A_MASK)), .mask_wdata(wdata),
    .clr_i(clr_vec), .set_i(set_vec), .sts_o(sts), .irq_o(irq));

  // ---------------- station address and multicast filter bytes
  for (genvar i = 0; i < STA_BYTES; i++) begin : g_sta
    logic en;
    assign en = reg_wr && page == PG_STATION && addr == AW'(STA_BASE + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sta_q[i] <= '0;
      else if (en) sta_q[i] <= wdata;
    end
  end
  for (genvar i = 0; i < MC_BYTES; i++) begin : g_mc
    logic en;
    assign en = reg_wr && page == PG_STATION && addr == AW'(MC_BASE + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mc_q[i] <= '0;
      else if (en) mc_q[i] <= wdata;
    end
  end

  // ---------------- read mux and registered read data
  always_comb begin
    rd_val = '0;
    if (addr == '0) begin
      rd_val = cmd_q;
    end else begin
      unique case (page)
        PG_MAIN: begin
          case (addr)
            A_BOUND:  rd_val = rs_bound;
            A_TXPG:   rd_val = txs_q;
            A_STATUS: rd_val = sts;
            A_DMA_LO: rd_val = dma_addr[7:0];
            A_DMA_HI: rd_val = dma_addr[15:8];
            A_CNT_LO: rd_val = ID_BYTE_A;
            A_CNT_HI: rd_val = ID_BYTE_B;
            default:  rd_val = '0;
          endcase
        end
        PG_STATION: begin
          if (addr == A_CURPG) rd_val = rs_cur;
          for (int i = 0; i < STA_BYTES; i++)
            if (addr == AW'(STA_BASE + i)) rd_val = sta_q[i];
          for (int i = 0; i < MC_BYTES; i++)
            if (addr == AW'(MC_BASE + i)) rd_val = mc_q[i];
        end
        PG_RINGRD: begin
          if (addr == A_RSTART)     rd_val = rs_start;
          else if (addr == A_RSTOP) rd_val = rs_stop;
        end
        default: rd_val = '0;
      endcase
    end
    rdata_d = rd ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata    = rdata_q;
  assign tx_start = txgo_q;
  assign tx_page  = txpg_q;
  assign rx_cfg   = rxc_q;
  assign data_cfg = dcf_q;

  // R1: writes at nonzero addresses leave the command byte alone
  a_r1_cmd_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != '0) |=> $stable(cmd_q));
  // R5: a remote command with zero count flags completion
  a_r5_dma_done: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_set |=> sts[SB_DMA_DONE]);
  // R6: the start pulse coincides with the completion report
  a_r6_tx_report: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (sts[SB_XMIT_DONE] && !cmd_q[CB_XMIT] && txs_q == XMIT_OK));
  // R6: a pulse lasts one cycle unless a fresh transmit command arrived
  a_r6_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !xmit_go) |=> !tx_start);
  // R10: without a read strobe the read data holds
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata_q));
  // CNT_B is the number of byte lanes per split register
  initial assert (CNT_B == 2);
endmodule

// File: tb/tb_nic_page_regs.sv
module tb_nic_page_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs, we;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq, tx_start;
  logic [7:0]  tx_page, rx_cfg, data_cfg;
  logic [15:0] tx_count, dma_addr, dma_count;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen;

  always #5 clk = ~clk;

  nic_page_regs dut (
    .clk, .rst_n, .cs, .we, .addr, .wdata, .rdata, .irq, .tx_start,
    .tx_page, .tx_count, .dma_addr, .dma_count, .rx_cfg, .data_cfg);

  // monitor: a read taken at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= rst_n && cs && !we;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string t);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 17) ^ 8'hA5);
  endfunction

  initial begin
    rd_seen = 1'b0;
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk(16'(irq), 16'h0, "R12 irq after reset");
    chk(16'(tx_start), 16'h0, "R12 tx_start after reset");
    rd(4'h0, 8'h01, "R12 command after reset");
    rd(4'h7, 8'h80, "R12 status after reset");

    // R3 bit 7 immune to W1C; R2 flag does not interrupt
    wr(4'h7, 8'hFF);
    rd(4'h7, 8'h80, "R3 reset flag survives status write");
    wr(4'hF, 8'h80);
    chk(16'(irq), 16'h0, "R2 reset flag masked in never raises irq");

    // R4 halted command keeps flag, running command clears it
    wr(4'h0, 8'h01);
    rd(4'h7, 8'h80, "R4 halt command keeps flag");
    wr(4'h0, 8'h00);
    rd(4'h7, 8'h00, "R4 run command clears flag");

    // R5 remote read with zero count
    wr(4'h0, 8'h08);
    chk(16'(irq), 16'h0, "R2 bit6 set but unmasked");
    rd(4'h7, 8'h40, "R5 dma-done set on zero count");
    wr(4'hF, 8'h40);
    chk(16'(irq), 16'h1, "R2 irq after mask write");
    wr(4'h7, 8'h40);
    chk(16'(irq), 16'h0, "R3 irq drops after clear");
    rd(4'h7, 8'h00, "R3 status cleared");

    // R7 split registers
    wr(4'h8, 8'h34); wr(4'h9, 8'h12);
    chk(dma_addr, 16'h1234, "R7 dma address both bytes");
    wr(4'h8, 8'h56);
    chk(dma_addr, 16'h1256, "R7 low byte keeps high");
    rd(4'h8, 8'h56, "R7 dma address low read");
    rd(4'h9, 8'h12, "R7 dma address high read");
    wr(4'hA, 8'h00); wr(4'hB, 8'h01);
    chk(dma_count, 16'h0100, "R7 dma count");
    wr(4'h5, 8'hEE); wr(4'h6, 8'h05);
    chk(tx_count, 16'h05EE, "R7 tx count");
    wr(4'h6, 8'h07);
    chk(tx_count, 16'h07EE, "R7 high byte keeps low");
    wr(4'hC, 8'h14);
    chk(16'(rx_cfg), 16'h14, "R7 receive config");
    wr(4'hE, 8'h49);
    chk(16'(data_cfg), 16'h49, "R7 data config");

    // R5 negative: nonzero count
    wr(4'h0, 8'h10);
    rd(4'h7, 8'h00, "R5 no dma-done with nonzero count");

    // R6 transmit
    wr(4'h4, 8'h40);
    chk(16'(tx_page), 16'h40, "R7 tx page");
    wr(4'h0, 8'h06);
    chk(16'(tx_start), 16'h1, "R6 tx_start pulse");
    @(negedge clk);
    chk(16'(tx_start), 16'h0, "R6 tx_start one cycle");
    rd(4'h0, 8'h02, "R6 command xmit bit cleared");
    rd(4'h4, 8'h01, "R6 transmit status");
    rd(4'h7, 8'h02, "R6 status bit1");
    chk(16'(irq), 16'h0, "R2 bit1 unmasked");
    wr(4'hF, 8'h02);
    chk(16'(irq), 16'h1, "R2 irq on bit1");
    wr(4'h7, 8'h02);
    chk(16'(irq), 16'h0, "R3 clear bit1");
    wr(4'h0, 8'h05);
    chk(16'(tx_start), 16'h0, "R6 halted transmit gives no pulse");
    rd(4'h0, 8'h05, "R6 halted command stored as written");
    rd(4'h7, 8'h00, "R6 halted transmit sets no status");

    // R8 ring limits and pointers (END_PAGE = 0x80)
    wr(4'h0, 8'h00);
    wr(4'h1, 8'h46); wr(4'h2, 8'h80); wr(4'h2, 8'h81); wr(4'h1, 8'h90);
    wr(4'h3, 8'h4C); wr(4'h3, 8'h80);
    rd(4'h3, 8'h4C, "R8 boundary at limit ignored");
    wr(4'h0, 8'h80);
    rd(4'h1, 8'h46, "R8 R9 ring start above limit ignored");
    rd(4'h2, 8'h80, "R8 R9 ring stop at limit accepted");
    rd(4'h0, 8'h80, "R1 command on page 2");
    wr(4'h0, 8'h40);
    wr(4'h7, 8'h7F); wr(4'h7, 8'h80);
    rd(4'h7, 8'h7F, "R8 current page at limit ignored");

    // R11 station and multicast bytes
    for (int i = 1; i <= 6; i++) wr(4'(i), pat(i));
    for (int i = 8; i <= 15; i++) wr(4'(i), pat(i));
    for (int i = 1; i <= 6; i++) rd(4'(i), pat(i), "R11 station byte");
    for (int i = 8; i <= 15; i++) rd(4'(i), pat(i), "R11 multicast byte");
    rd(4'h0, 8'h40, "R1 command on page 1");

    // R9 unmapped and identification reads; R1 page-1 writes missed page 0
    wr(4'h0, 8'hC0);
    rd(4'h5, 8'h00, "R9 page 3 unmapped");
    wr(4'h0, 8'h00);
    rd(4'h1, 8'h00, "R9 page 0 write-only address reads 0");
    rd(4'h7, 8'h00, "R1 page 1 writes left status alone");
    rd(4'hC, 8'h00, "R9 page 0 address 12 reads 0");
    rd(4'hA, 8'h50, "R9 id byte A");
    rd(4'hB, 8'h43, "R9 id byte B");

    // R10 read data holds across a write
    wr(4'h5, 8'h11);
    chk(16'(rdata), 16'h43, "R10 rdata held over write");
    @(negedge clk);
    chk(16'(rdata), 16'h43, "R10 rdata held idle");
    chk(16'(exp_q.size()), 16'h0, "R10 every read produced data");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule